// File: doc/BRIEF.md
# PLL Divider Triple Search Engine

This block picks the reference divider M, the feedback multiplier N and the power-of-two post divider P for a PLL whose output is ref·N/(M·P). All frequencies are unsigned integers in kHz. A pulse on `start` captures the requested frequency, the reference frequency and every limit. The engine then clamps the request into the range the PLL can reach. It walks P upward through powers of two and, inside each P, walks M upward through its allowed range. For every pair that passes the VCO range check and the phase-discriminator window check, it computes a rounded N. A shared sequential divider produces N and then the achieved frequency, and the engine keeps the triple with the smallest absolute error.

When the walk ends, `done` is high for one cycle. Together with it come `valid`, the chosen M and N, P as its base-2 logarithm, the achieved frequency, and a packed 24-bit word ready to write into a PLL control register. These results hold until the next accepted `start`. If no pair survives the checks, `valid` is low and every result field reads zero.

Top module: `pll_mnp_search`

## Requirements
- R1: After reset, `done` and `valid` are 0, and `m_out`, `n_out`, `p_log2`, `f_out_khz` and `pll_word` are all 0.
- R2: A request below `vco_min_khz >> p_log2_max` is raised to `vco_min_khz >> p_log2_max` before the search starts.
- R3: After the R2 raise, a request above `max_out_khz` is lowered to `max_out_khz`; this lowering takes precedence.
- R4: P takes the values 2^k for k = 0 up to `p_log2_max`, in ascending order. A P is used only when request·P lies within [`vco_min_khz`, `vco_max_khz`], both ends included.
- R5: For each usable P, M runs from `m_min` to `m_max` in ascending order. An M is used only when `disc_lo_khz`·M ≤ `ref_khz` ≤ `disc_hi_khz`·M.
- R6: N = floor((2·request·P·M + ref)/(2·ref)), which is request·P·M/ref rounded half up. A candidate with N < 1 or N > 255 is dropped.
- R7: The achieved frequency is floor(ref·N/(M·P)) and the error is |request − achieved|. A candidate replaces the best so far only when its error is strictly smaller, so on a tie the candidate reached first keeps the slot.
- R8: `p_log2` reports k, where P = 2^k. `pll_word` packs `p_log2` in bits 23:16, N in bits 15:8 and M in bits 7:0, with the unused bits of each byte set to zero.
- R9: `done` is high for exactly one cycle when the search ends. If no candidate survived, `valid` is 0 and M, N, `p_log2` and `f_out_khz` read 0.
- R10: All inputs are sampled on the cycle that `start` is accepted. A `start` pulse while a search is running, and any input change during that search, does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Starts a search when the engine is idle |
| req_khz | input | FW | Requested output frequency |
| ref_khz | input | FW | Reference frequency |
| vco_min_khz | input | FW | Lowest permitted VCO frequency |
| vco_max_khz | input | FW | Highest permitted VCO frequency |
| max_out_khz | input | FW | Highest permitted output frequency |
| disc_lo_khz | input | FW | Lower edge of the phase-discriminator window |
| disc_hi_khz | input | FW | Upper edge of the phase-discriminator window |
| m_min | input | MW | First M value to try |
| m_max | input | MW | Last M value to try |
| p_log2_max | input | PLW | log2 of the largest P |
| done | output | 1 | One-cycle end-of-search strobe |
| valid | output | 1 | At least one candidate was found |
| m_out | output | MW | Chosen M |
| n_out | output | 8 | Chosen N |
| p_log2 | output | PLW | log2 of the chosen P |
| f_out_khz | output | FW | Achieved output frequency |
| pll_word | output | 24 | Packed control word {P code, N, M} |

## Verification
The search length depends on how many pairs pass the checks: each surviving pair costs two full divider passes, and each rejected P or M costs a single cycle. For that reason no result has a fixed latency. The results are due only on the cycle in which `done` is high, and they stay stable from then until the next accepted start. The bench drives `start` for exactly one clock, polls `done` on every falling edge under a per-search cycle limit, and samples every result in the same half cycle in which `done` is seen. One falling edge later it confirms that `done` has dropped. Expected triples come from an integer walk in the bench that follows R2 through R7. The tie case and the cases with no surviving candidate are also checked against hand-worked values.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_PCHK  = 3'd1,
    S_MCHK  = 3'd2,
    S_NWAIT = 3'd3,
    S_FWAIT = 3'd4,
    S_DONE  = 3'd5
  } srch_state_t;
endpackage

// File: rtl/pll_div.sv
// Restoring divider: one quotient bit per cycle, W cycles per operation.
module pll_div #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, rem_d, quo_q, quo_d, dsr_q, dsr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d, done_q, done_d, en;
  logic [W:0]    shifted, diff;

  assign shifted = {rem_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, dsr_q};
  assign en      = go | run_q | done_q;

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    dsr_d  = dsr_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (go) begin
      rem_d = '0;
      quo_d = dividend;
      dsr_d = divisor;
      cnt_d = CW'(W);
      run_d = 1'b1;
    end else if (run_q) begin
      if (shifted >= {1'b0, dsr_q}) begin
        rem_d = diff[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_d = shifted[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b0};
      end
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (en) begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dsr_q  <= dsr_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign quotient = quo_q;
  assign done     = done_q;

  AST_DIV_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !run_q);  // R6
endmodule

// File: rtl/pll_window_chk.sv
// Combinational VCO range and discriminator window tests (no division).
module pll_window_chk #(
  parameter int FW  = 20,
  parameter int MCW = 5,
  parameter int PCW = 4,
  parameter int DW  = 33
) (
  input  logic [FW-1:0]  req,
  input  logic [PCW-1:0] plog,
  input  logic [FW-1:0]  vco_lo,
  input  logic [FW-1:0]  vco_hi,
  input  logic [FW-1:0]  ref_f,
  input  logic [MCW-1:0] m,
  input  logic [FW-1:0]  win_lo,
  input  logic [FW-1:0]  win_hi,
  output logic           vco_ok,
  output logic           win_ok
);
  localparam int PW = FW + MCW;

  logic [DW-1:0] vco_f;
  logic [PW-1:0] lo_m, hi_m, ref_x;

  assign vco_f  = DW'(req) << plog;
  assign vco_ok = (vco_f >= DW'(vco_lo)) && (vco_f <= DW'(vco_hi));
  assign lo_m   = PW'(win_lo) * PW'(m);
  assign hi_m   = PW'(win_hi) * PW'(m);
  assign ref_x  = PW'(ref_f);
  assign win_ok = (ref_x >= lo_m) && (ref_x <= hi_m);
endmodule

// File: rtl/pll_mnp_search.sv
module pll_mnp_search
  import pll_search_pkg::*;
#(
  parameter int FW  = 20,
  parameter int MW  = 4,
  parameter int PLW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [FW-1:0]  req_khz,
  input  logic [FW-1:0]  ref_khz,
  input  logic [FW-1:0]  vco_min_khz,
  input  logic [FW-1:0]  vco_max_khz,
  input  logic [FW-1:0]  max_out_khz,
  input  logic [FW-1:0]  disc_lo_khz,
  input  logic [FW-1:0]  disc_hi_khz,
  input  logic [MW-1:0]  m_min,
  input  logic [MW-1:0]  m_max,
  input  logic [PLW-1:0] p_log2_max,
  output logic           done,
  output logic           valid,
  output logic [MW-1:0]  m_out,
  output logic [7:0]     n_out,
  output logic [PLW-1:0] p_log2,
  output logic [FW-1:0]  f_out_khz,
  output logic [23:0]    pll_word
);
  localparam int NW  = 8;
  localparam int DW  = FW + MW + (2 ** PLW) + 1;
  localparam int MCW = MW + 1;
  localparam int PCW = PLW + 1;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  // captured request and limits
  logic [FW-1:0]  req_q, ref_q, vmin_q, vmax_q, dlo_q, dhi_q;
  logic [MW-1:0]  mmin_q, mmax_q;
  logic [PLW-1:0] plmax_q;
  logic [FW-1:0]  low_bound, req_lo, req_cl;
  logic           load;

  assign low_bound = vco_min_khz >> p_log2_max;
  assign req_lo    = (req_khz < low_bound) ? low_bound : req_khz;
  assign req_cl    = (req_lo > max_out_khz) ? max_out_khz : req_lo;

  srch_state_t   st_q, st_d;
  logic [PCW-1:0] pl_q, pl_d;
  logic [MCW-1:0] m_q, m_d;
  logic [NW-1:0]  n_q, n_d, bn_q, bn_d;
  logic [MW-1:0]  bm_q, bm_d;
  logic [PLW-1:0] bp_q, bp_d;
  logic [FW-1:0]  bf_q, bf_d;
  logic [DW-1:0]  berr_q, berr_d;
  logic           found_q, found_d, done_q, done_d;

  assign load = (st_q == S_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      req_q <= '0; ref_q <= '0; vmin_q <= '0; vmax_q <= '0;
      dlo_q <= '0; dhi_q <= '0; mmin_q <= '0; mmax_q <= '0; plmax_q <= '0;
    end else if (load) begin
      req_q   <= req_cl;
      ref_q   <= ref_khz;
      vmin_q  <= vco_min_khz;
      vmax_q  <= vco_max_khz;
      dlo_q   <= disc_lo_khz;
      dhi_q   <= disc_hi_khz;
      mmin_q  <= m_min;
      mmax_q  <= m_max;
      plmax_q <= p_log2_max;
    end
  end

  // candidate checks and shared divider
  logic          vco_ok, win_ok, div_go, div_done, n_bad;
  logic [DW-1:0] div_dvd, div_dvs, div_q, req_x, err;

  pll_window_chk #(.FW(FW), .MCW(MCW), .PCW(PCW), .DW(DW)) u_chk (
    .req(req_q), .plog(pl_q), .vco_lo(vmin_q), .vco_hi(vmax_q),
    .ref_f(ref_q), .m(m_q), .win_lo(dlo_q), .win_hi(dhi_q),
    .vco_ok(vco_ok), .win_ok(win_ok)
  );

  pll_div #(.W(DW)) u_div (
    .clk(clk), .rst_n(rst_n_i), .go(div_go), .dividend(div_dvd),
    .divisor(div_dvs), .quotient(div_q), .done(div_done)
  );

  assign req_x = DW'(req_q);
  assign n_bad = (div_q == '0) || (div_q > DW'(255));
  assign err   = (div_q > req_x) ? (div_q - req_x) : (req_x - div_q);

  always_comb begin
    st_d = st_q; pl_d = pl_q; m_d = m_q; n_d = n_q;
    bm_d = bm_q; bn_d = bn_q; bp_d = bp_q; bf_d = bf_q; berr_d = berr_q;
    found_d = found_q;
    done_d  = 1'b0;
    div_go  = 1'b0;
    // N = (2*req*P*M + ref) / (2*ref)
    div_dvd = (((req_x * DW'(m_q)) << pl_q) << 1) + DW'(ref_q);
    div_dvs = DW'(ref_q) << 1;
    case (st_q)
      S_IDLE: if (start) begin
        st_d = S_PCHK; pl_d = '0; found_d = 1'b0; berr_d = '1;
        bm_d = '0; bn_d = '0; bp_d = '0; bf_d = '0;
      end
      S_PCHK: begin
        if (pl_q > {1'b0, plmax_q}) st_d = S_DONE;
        else if (vco_ok) begin
          m_d  = MCW'(mmin_q);
          st_d = S_MCHK;
        end else pl_d = pl_q + 1'b1;
      end
      S_MCHK: begin
        if (m_q > {1'b0, mmax_q}) begin
          pl_d = pl_q + 1'b1;
          st_d = S_PCHK;
        end else if (win_ok) begin
          div_go = 1'b1;
          st_d   = S_NWAIT;
        end else m_d = m_q + 1'b1;
      end
      S_NWAIT: begin
        // achieved = ref*N / (M*P)
        div_dvd = DW'(ref_q) * DW'(div_q[NW-1:0]);
        div_dvs = DW'(m_q) << pl_q;
        if (div_done) begin
          if (n_bad) begin
            m_d  = m_q + 1'b1;
            st_d = S_MCHK;
          end else begin
            n_d    = div_q[NW-1:0];
            div_go = 1'b1;
            st_d   = S_FWAIT;
          end
        end
      end
      S_FWAIT: if (div_done) begin
        if (err < berr_q) begin
          berr_d = err; found_d = 1'b1;
          bm_d = m_q[MW-1:0]; bn_d = n_q; bp_d = pl_q[PLW-1:0];
          bf_d = div_q[FW-1:0];
        end
        m_d  = m_q + 1'b1;
        st_d = S_MCHK;
      end
      S_DONE: begin
        done_d = 1'b1;
        st_d   = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q <= S_IDLE; pl_q <= '0; m_q <= '0; n_q <= '0;
      bm_q <= '0; bn_q <= '0; bp_q <= '0; bf_q <= '0; berr_q <= '1;
      found_q <= 1'b0; done_q <= 1'b0;
    end else begin
      st_q <= st_d; pl_q <= pl_d; m_q <= m_d; n_q <= n_d;
      bm_q <= bm_d; bn_q <= bn_d; bp_q <= bp_d; bf_q <= bf_d; berr_q <= berr_d;
      found_q <= found_d; done_q <= done_d;
    end
  end

  assign done      = done_q;
  assign valid     = found_q;
  assign m_out     = bm_q;
  assign n_out     = bn_q;
  assign p_log2    = bp_q;
  assign f_out_khz = bf_q;
  assign pll_word  = {{(8 - PLW){1'b0}}, bp_q, bn_q, {(8 - MW){1'b0}}, bm_q};

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n_i)
    done_q |=> !done_q);  // R9
  AST_M_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n_i)
    (done_q && found_q) |-> (bm_q >= mmin_q && bm_q <= mmax_q));  // R5
  AST_P_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n_i)
    (done_q && found_q) |-> (bp_q <= plmax_q));  // R4
  AST_N_NONZERO: assert property (@(posedge clk) disable iff (!rst_n_i)
    (done_q && found_q) |-> (bn_q != '0));  // R6
  AST_ERR_NEVER_GROWS: assert property (@(posedge clk) disable iff (!rst_n_i)
    (st_q != S_IDLE && $past(st_q) != S_IDLE) |-> (berr_q <= $past(berr_q)));  // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n_i)
    (st_q != S_IDLE && $past(st_q) != S_IDLE) |-> $stable(req_q));  // R10
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n_i)
    (done_q && !found_q) |-> (pll_word == 24'd0));  // R9
endmodule

// File: tb/pll_mnp_search_tb.sv
module pll_mnp_search_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_LIMIT = 40000;

  logic        clk, rst_n, start;
  logic [19:0] req_khz, ref_khz, vco_min_khz, vco_max_khz, max_out_khz;
  logic [19:0] disc_lo_khz, disc_hi_khz;
  logic [3:0]  m_min, m_max;
  logic [2:0]  p_log2_max;
  logic        done, valid;
  logic [3:0]  m_out;
  logic [7:0]  n_out;
  logic [2:0]  p_log2;
  logic [19:0] f_out_khz;
  logic [23:0] pll_word;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit timed_out;

  pll_mnp_search dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .req_khz(req_khz), .ref_khz(ref_khz),
    .vco_min_khz(vco_min_khz), .vco_max_khz(vco_max_khz), .max_out_khz(max_out_khz),
    .disc_lo_khz(disc_lo_khz), .disc_hi_khz(disc_hi_khz), .m_min(m_min), .m_max(m_max),
    .p_log2_max(p_log2_max), .done(done), .valid(valid), .m_out(m_out), .n_out(n_out),
    .p_log2(p_log2), .f_out_khz(f_out_khz), .pll_word(pll_word)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cycles++;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // integer walk written from R2..R7
  function automatic void model(input longint rq, rf, vmn, vmx, mxo, dlo, dhi, mmn, mmx, plm,
                                output bit ok, output longint bm, bn, bp, bf);
    longint r, lb, best, n, f, e, v;
    lb = vmn >> plm;
    r = (rq < lb) ? lb : rq;
    if (r > mxo) r = mxo;
    best = 64'h7fffffffffffffff;
    ok = 0; bm = 0; bn = 0; bp = 0; bf = 0;
    for (int pl = 0; pl <= plm; pl++) begin
      v = r << pl;
      if (v < vmn || v > vmx) continue;
      for (int m = int'(mmn); m <= int'(mmx); m++) begin
        if (dlo * m > rf || dhi * m < rf) continue;
        n = (2 * r * (64'd1 << pl) * m + rf) / (2 * rf);
        if (n < 1 || n > 255) continue;
        f = (rf * n) / (m * (64'd1 << pl));
        e = (f > r) ? f - r : r - f;
        if (e < best) begin
          best = e; ok = 1; bm = m; bn = n; bp = pl; bf = f;
        end
      end
    end
  endfunction

  task automatic setup(input int rq, rf, vmn, vmx, mxo, dlo, dhi, mmn, mmx, plm);
    @(negedge clk);
    req_khz = 20'(rq); ref_khz = 20'(rf); vco_min_khz = 20'(vmn); vco_max_khz = 20'(vmx);
    max_out_khz = 20'(mxo); disc_lo_khz = 20'(dlo); disc_hi_khz = 20'(dhi);
    m_min = 4'(mmn); m_max = 4'(mmx); p_log2_max = 3'(plm);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    timed_out = 0;
    while (done !== 1'b1 && n < WAIT_LIMIT) begin
      @(negedge clk);
      n++;
    end
    if (done !== 1'b1) begin
      timed_out = 1;
      check(0, {req, " watchdog"}, n, WAIT_LIMIT);
    end
  endtask

  task automatic compare_model(input string req);
    bit ok; longint bm, bn, bp, bf;
    model(req_khz, ref_khz, vco_min_khz, vco_max_khz, max_out_khz, disc_lo_khz,
          disc_hi_khz, m_min, m_max, p_log2_max, ok, bm, bn, bp, bf);
    check(valid == ok, {req, " valid"}, valid, ok);
    check(m_out == bm, {req, " M"}, m_out, bm);
    check(n_out == bn, {req, " N"}, n_out, bn);
    check(p_log2 == bp, {req, " P code"}, p_log2, bp);
    check(f_out_khz == bf, {req, " f_out"}, f_out_khz, bf);
    check(pll_word == 24'((bp << 16) | (bn << 8) | bm), {req, " R8 word"}, pll_word,
          (bp << 16) | (bn << 8) | bm);
  endtask

  task automatic run_and_compare(input string req, input int rq, rf, vmn, vmx, mxo,
                                 dlo, dhi, mmn, mmx, plm);
    setup(rq, rf, vmn, vmx, mxo, dlo, dhi, mmn, mmx, plm);
    wait_done(req);
    if (!timed_out) begin
      compare_model(req);
      @(negedge clk);
      check(done == 1'b0, "R9 done one cycle", done, 0);
    end
  endtask

  task automatic t_reset();
    check(done == 1'b0, "R1 done", done, 0);
    check(valid == 1'b0, "R1 valid", valid, 0);
    check(pll_word == 24'd0, "R1 word", pll_word, 0);
    check(f_out_khz == 20'd0, "R1 f_out", f_out_khz, 0);
  endtask

  task automatic t_tie();
    // P=1,M=2 and P=2,M=1 both hit 3000 exactly; first reached must stay
    setup(3000, 2000, 1000, 100000, 100000, 1000, 2000, 1, 2, 2);
    wait_done("R7 tie");
    if (!timed_out) begin
      check(valid == 1'b1, "R7 tie valid", valid, 1);
      check(m_out == 4'd2, "R7 tie M", m_out, 2);
      check(n_out == 8'd3, "R7 tie N", n_out, 3);
      check(p_log2 == 3'd0, "R7 tie P code", p_log2, 0);
      check(f_out_khz == 20'd3000, "R7 tie f_out", f_out_khz, 3000);
      check(pll_word == 24'h000302, "R8 tie word", pll_word, 24'h000302);
    end
  endtask

  task automatic t_empty_window();
    // ref/M never reaches 5000 for M in 7..14
    setup(25175, 14318, 128000, 350000, 350000, 5000, 6000, 7, 14, 4);
    wait_done("R9 empty");
    if (!timed_out) begin
      check(valid == 1'b0, "R9 empty valid", valid, 0);
      check(pll_word == 24'd0, "R9 empty word", pll_word, 0);
      check(f_out_khz == 20'd0, "R9 empty f_out", f_out_khz, 0);
    end
  endtask

  task automatic t_n_overflow();
    // N = 300*M for every M in 1..15, always above 255
    setup(300000, 1000, 1000, 1000000, 1000000, 1, 1000, 1, 15, 0);
    wait_done("R6 N limit");
    if (!timed_out) begin
      check(valid == 1'b0, "R6 N over 255 dropped", valid, 0);
      check(n_out == 8'd0, "R6 N field", n_out, 0);
    end
  endtask

  task automatic t_restart_ignored();
    bit ok; longint bm, bn, bp, bf;
    model(25175, 14318, 128000, 350000, 350000, 1000, 2000, 7, 14, 4, ok, bm, bn, bp, bf);
    setup(25175, 14318, 128000, 350000, 350000, 1000, 2000, 7, 14, 4);
    repeat (30) @(negedge clk);
    req_khz = 20'd65000; m_min = 4'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R10 restart");
    if (!timed_out) begin
      check(m_out == 4'(bm), "R10 M kept", m_out, bm);
      check(n_out == 8'(bn), "R10 N kept", n_out, bn);
      check(f_out_khz == 20'(bf), "R10 f_out kept", f_out_khz, bf);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0;
    req_khz = '0; ref_khz = '0; vco_min_khz = '0; vco_max_khz = '0; max_out_khz = '0;
    disc_lo_khz = '0; disc_hi_khz = '0; m_min = '0; m_max = '0; p_log2_max = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    run_and_compare("R4 R5 R6 R7 typical", 25175, 14318, 128000, 350000, 350000, 1000, 2000, 7, 14, 4);
    run_and_compare("R4 R7 mid", 65000, 14318, 128000, 350000, 350000, 1000, 2000, 7, 14, 4);
    run_and_compare("R2 low clamp", 100, 14318, 128000, 350000, 350000, 1000, 2000, 7, 14, 4);
    run_and_compare("R3 high clamp", 900000, 14318, 128000, 350000, 200000, 1000, 2000, 7, 14, 4);
    run_and_compare("R4 R5 wide P", 13500, 27000, 200000, 600000, 400000, 1700, 6400, 4, 14, 5);
    t_tie();
    t_empty_window();
    t_n_overflow();
    t_restart_ignored();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    checks++;
    $display("FAIL watchdog expired at cycle %0d expected completion", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule